// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block turns the digital outcomes of a supply monitor, a manual reset button and a watchdog into the reset line for a processor. It takes three inputs. The first is a supply-undervoltage flag that is already synchronized. The second is a debounced active-low manual reset. The third is a one-cycle watchdog expiry strobe. From these it produces one reset state, which leaves the block on a low-true output, on a high-true output and on a status flag.

A hold counter stretches every reset. Level causes are the undervoltage flag and the manual input. These keep reset asserted for as long as they are present and keep the counter at zero. Counting starts only when the last cause goes away, and reset is released `TREC_CYCLES` cycles later. A watchdog strobe restarts the same hold. When reset is idle, the strobe therefore gives a pulse of exactly `TREC_CYCLES` cycles. Any new cause that arrives during a hold restarts the hold from zero.

Top module: `sup_rst_gen`

## Requirements
- R1: When `supply_low_i` is high at a clock edge, the reset is asserted after that edge and stays asserted while `supply_low_i` stays high.
- R2: After `supply_low_i` was last seen high at edge N, reset stays asserted through edge N+`TREC_CYCLES`-1 and is released after edge N+`TREC_CYCLES`.
- R3: If the supply dips low during a hold, the hold counter restarts from zero, and release comes `TREC_CYCLES` edges after the dip clears.
- R4: A low level on `mr_ni` asserts reset for as long as it is low, and for `TREC_CYCLES` cycles after it returns high.
- R5: A single-cycle high on `wdt_expire_i` while reset is idle gives a reset pulse of exactly `TREC_CYCLES` cycles.
- R6: Any cause (watchdog strobe or manual reset) that arrives during a hold restarts the hold, so release comes `TREC_CYCLES` edges after the newest cause.
- R7: `sys_rst_no` is 0 while reset is asserted and 1 otherwise. `sys_rst_o` and `rst_active_o` are 1 while reset is asserted and 0 otherwise.
- R8: While `rst_ni` is low the reset is asserted. After `rst_ni` rises, with no cause present, reset is released `TREC_CYCLES` edges later.
- R9: Once released, reset stays released for as long as no cause is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| supply_low_i | input | 1 | Supply below threshold, synchronized, active high |
| mr_ni | input | 1 | Manual reset, debounced, active low |
| wdt_expire_i | input | 1 | Watchdog expiry strobe, one cycle |
| sys_rst_no | output | 1 | Reset to processor, active low |
| sys_rst_o | output | 1 | Reset to processor, active high |
| rst_active_o | output | 1 | Reset asserted status |

## Verification
Assertion is due one edge after a cause is sampled. Release is due at the `TREC_CYCLES`-th edge after the last edge that saw a cause. The exception is the block reset, which asserts at once without waiting for a clock. The bench drives inputs on the falling edge and samples all three outputs 5 ns after the rising edge that consumed them. Each stimulus run in the vector table therefore lists exactly how many samples stay asserted before the single released sample. The directed block-reset test samples shortly after `rst_ni` falls, and then counts edges from the rise of `rst_ni`.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_RUN  = 1'b1
  } hold_st_e;
endpackage

// File: rtl/sup_rst_cause.sv
module sup_rst_cause (
  input  logic supply_low_i,
  input  logic mr_ni,
  input  logic wdt_expire_i,
  output logic restart_o
);
  // level causes and the watchdog strobe all clear the hold
  assign restart_o = supply_low_i | ~mr_ni | wdt_expire_i;
endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold
  import sup_rst_pkg::*;
#(
  parameter int unsigned TREC_CYCLES = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic active_o
);
  localparam int unsigned CNT_W = (TREC_CYCLES > 2) ? $clog2(TREC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TREC_CYCLES - 1);
  localparam int unsigned SW = $clog2(TREC_CYCLES + 2);

  hold_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HOLD_RUN;
      cnt_q <= '0;
    end else if (restart_i) begin
      st_q  <= HOLD_RUN;
      cnt_q <= '0;
    end else if (st_q == HOLD_RUN) begin
      if (cnt_q == LAST) begin
        st_q  <= HOLD_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = (st_q == HOLD_RUN);

  // checker-only: cycles since the last restart, saturating
  logic [SW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= '0;
    else if (restart_i)         since_q <= '0;
    else if (since_q != '1)     since_q <= since_q + 1'b1;
  end

  // R1
  restart_asserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> active_o);

  // R2
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> (since_q == SW'(TREC_CYCLES)));

  // R9
  quiet_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !restart_i) |=> !active_o);

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R6
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (since_q == '0) && active_o);
endmodule

// File: rtl/sup_rst_drive.sv
module sup_rst_drive (
  input  logic active_i,
  output logic rst_no,
  output logic rst_o,
  output logic active_o
);
  assign rst_no   = ~active_i;
  assign rst_o    = active_i;
  assign active_o = active_i;
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
  parameter int unsigned TREC_CYCLES = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_low_i,
  input  logic mr_ni,
  input  logic wdt_expire_i,
  output logic sys_rst_no,
  output logic sys_rst_o,
  output logic rst_active_o
);
  logic restart;
  logic active;

  sup_rst_cause u_cause (
    .supply_low_i (supply_low_i),
    .mr_ni        (mr_ni),
    .wdt_expire_i (wdt_expire_i),
    .restart_o    (restart)
  );

  sup_rst_hold #(.TREC_CYCLES(TREC_CYCLES)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .active_o  (active)
  );

  sup_rst_drive u_drive (
    .active_i (active),
    .rst_no   (sys_rst_no),
    .rst_o    (sys_rst_o),
    .active_o (rst_active_o)
  );

  // R7
  polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no != sys_rst_o);

  // R4
  mr_asserts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_ni |=> (sys_rst_o && !sys_rst_no));
endmodule

// File: tb/sup_rst_gen_test.sv
module sup_rst_gen_test;
  localparam int unsigned TREC = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic wdt = 1'b0;
  logic rst_n_out, rst_out, active_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sup_rst_gen #(.TREC_CYCLES(TREC)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .supply_low_i (supply_low),
    .mr_ni        (mr_n),
    .wdt_expire_i (wdt),
    .sys_rst_no   (rst_n_out),
    .sys_rst_o    (rst_out),
    .rst_active_o (active_out)
  );

  // entry: {req[3:0], reps[3:0], supply_low, mr_n, wdt, expected_reset}
  localparam int NV = 24;
  localparam logic [11:0] VEC [NV] = '{
    {4'd8, 4'd7, 4'b0101},  // R8 hold after block reset
    {4'd9, 4'd3, 4'b0100},  // R9 released, quiet
    {4'd1, 4'd3, 4'b1101},  // R1 supply low
    {4'd2, 4'd7, 4'b0101},  // R2 hold
    {4'd2, 4'd2, 4'b0100},  // R2 release
    {4'd3, 4'd1, 4'b1101},  // R3 supply low
    {4'd3, 4'd4, 4'b0101},  // R3 partial hold
    {4'd3, 4'd1, 4'b1101},  // R3 dip restarts
    {4'd3, 4'd7, 4'b0101},  // R3 full hold
    {4'd3, 4'd2, 4'b0100},
    {4'd4, 4'd2, 4'b0001},  // R4 manual low
    {4'd4, 4'd7, 4'b0101},
    {4'd4, 4'd2, 4'b0100},
    {4'd5, 4'd1, 4'b0111},  // R5 watchdog strobe
    {4'd5, 4'd7, 4'b0101},
    {4'd5, 4'd2, 4'b0100},
    {4'd6, 4'd1, 4'b0111},  // R6 strobe
    {4'd6, 4'd3, 4'b0101},
    {4'd6, 4'd1, 4'b0001},  // R6 manual during hold
    {4'd6, 4'd7, 4'b0101},
    {4'd6, 4'd1, 4'b0100},
    {4'd1, 4'd2, 4'b1011},  // R1 all causes together
    {4'd1, 4'd7, 4'b0101},
    {4'd9, 4'd5, 4'b0100}   // R9 stays released
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input int req, input logic exp);
    chk(req, "sys_rst_o", rst_out, exp);
    chk(7, "sys_rst_no", rst_n_out, ~exp);    // R7
    chk(7, "rst_active_o", active_out, exp);  // R7
  endtask

  task automatic step(input int req, input logic sl, input logic mn, input logic wd,
                      input logic exp);
    supply_low = sl;
    mr_n = mn;
    wdt = wd;
    @(posedge clk);
    #5;
    chk_all(req, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all(8, 1'b1);  // R8 reset state
    rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < int'(VEC[v][7:4]); r++)
        step(int'(VEC[v][11:8]), VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R8 block reset in the middle of a hold
    step(5, 1'b0, 1'b1, 1'b1, 1'b1);
    step(5, 1'b0, 1'b1, 1'b0, 1'b1);
    #3 rst_ni = 1'b0;
    #2 chk_all(8, 1'b1);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < int'(TREC) - 1; k++) step(8, 1'b0, 1'b1, 1'b0, 1'b1);
    step(8, 1'b0, 1'b1, 1'b0, 1'b0);
    step(9, 1'b0, 1'b1, 1'b0, 1'b0);

    // R5 back-to-back strobes: second one restarts the pulse
    step(5, 1'b0, 1'b1, 1'b1, 1'b1);
    step(6, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < int'(TREC) - 1; k++) step(6, 1'b0, 1'b1, 1'b0, 1'b1);
    step(6, 1'b0, 1'b1, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule